// File: doc/BRIEF.md
# Debug Mailbox Register with Access Gating

This block is a one-byte mailbox that lets software on a running CPU hand data to an external debugger. The CPU writes a byte over its I/O bus. That write also raises a dirty flag, which tells the debugger that fresh data is waiting. The debugger side sees the full stored byte and the flag. Once the debugger has taken the byte, it clears the flag with a one-cycle acknowledge. When the CPU reads the mailbox back, it gets the low seven data bits, and the top bit is replaced by the dirty flag. The CPU therefore learns whether the debugger has consumed the last byte.

The mailbox shares its I/O address (0x31, which is 0x51 in data memory space) with an ordinary 8-bit register. The CPU reaches the mailbox only while the debug-enable fuse is programmed and the debugger has opened access. In every other case, reads and writes at that address go to the ordinary register.

A small non-volatile configuration section holds the fuse and two lock bits. While either lock bit is programmed, requests to change the fuse are refused. A chip erase clears the locks and lifts that block. The fuse keeps its value through a normal reset and is cleared only by the power-on reset of the non-volatile cells.

Top module: `dbgmb_top`

## Requirements
- R1: After `rst`, the mailbox byte, the dirty flag and the ordinary register are all 0. After `nv_rst`, the fuse and both lock bits are 0.
- R2: With the gate open, a CPU write at address 0x31 stores the byte. At the same clock edge, it sets the dirty flag to 1.
- R3: With the gate open, a CPU read at address 0x31 returns the dirty flag in bit 7 and stored bits 6:0 in bits 6:0.
- R4: `dbg_data_o` always shows all 8 stored mailbox bits, and `dbg_dirty_o` shows the dirty flag.
- R5: A debugger acknowledge clears the dirty flag at the next edge. CPU reads never clear it.
- R6: When a mailbox write and an acknowledge fall in the same cycle, the new byte is stored and the dirty flag stays 1.
- R7: The gate is open only when `fuse_o` is 1 and `dbg_en_i` is 1. While the gate is closed, reads and writes at 0x31 reach a plain 8-bit read/write register, and the mailbox byte and dirty flag stay unchanged.
- R8: An access at any address other than 0x31 changes neither register, and a read there returns 0.
- R9: While either bit of `lock_o` is 1, a fuse write request leaves `fuse_o` unchanged.
- R10: Lock bits can only be set by lock writes, never cleared by them. A chip erase clears both lock bits and wins over a lock write in the same cycle. After that, fuse writes take effect. The fuse value survives `rst`.
- R11: `io_rdata_o` is 0 whenever `io_rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for the mailbox and the ordinary register |
| nv_rst | input | 1 | Synchronous active-high power-on reset for the fuse and lock cells |
| io_addr_i | input | 6 | CPU I/O address |
| io_wr_i | input | 1 | CPU write strobe |
| io_rd_i | input | 1 | CPU read strobe |
| io_wdata_i | input | 8 | CPU write data |
| io_rdata_o | output | 8 | CPU read data (combinational, 0 when not reading) |
| dbg_en_i | input | 1 | Debugger access enable for the mailbox |
| dbg_ack_i | input | 1 | Debugger acknowledge pulse that clears the dirty flag |
| dbg_data_o | output | 8 | Full stored mailbox byte for the debugger |
| dbg_dirty_o | output | 1 | Dirty flag: unread data waiting |
| lock_wr_i | input | 1 | Lock-bit program request |
| lock_val_i | input | 2 | Lock bits to program (1 = program) |
| fuse_wr_i | input | 1 | Debug-enable fuse write request |
| fuse_val_i | input | 1 | New fuse value (1 = programmed) |
| chip_erase_i | input | 1 | Chip erase request |
| fuse_o | output | 1 | Current debug-enable fuse value |
| lock_o | output | 2 | Current lock bits |

## Verification
Two pairs of functions can land on the same cycle. The first pair is a CPU mailbox write and a debugger acknowledge, which compete for the dirty flag. The bench drives both strobes in one cycle. It passes only if the new byte appears and the flag reads 1 afterwards. The second pair is a chip erase and a lock write. The bench issues them together and expects both lock bits to be 0. It then confirms that a following fuse write is accepted.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
    localparam int DW = 8;
    localparam int AW = 6;
    localparam logic [AW-1:0] MBOX_IO_ADDR = 6'h31;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        byte_t         wdata;
    } io_req_t;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_STD  = 2'd1,
        RT_MBOX = 2'd2
    } route_e;

    // CPU view of the mailbox: top bit carries the dirty flag
    function automatic byte_t cpu_view(byte_t d, logic dirty);
        return {dirty, d[DW-2:0]};
    endfunction

    function automatic route_e pick_route(logic hit, logic gate);
        if (!hit)     return RT_NONE;
        else if (gate) return RT_MBOX;
        else           return RT_STD;
    endfunction
endpackage

// File: rtl/dbgmb_mailbox.sv
module dbgmb_mailbox
    import dbgmb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wdata,
    input  logic  ack,
    output byte_t data_o,
    output logic  dirty_o
);
    byte_t data_q;
    logic  dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            dirty_q <= 1'b0;
        end else begin
            if (wr_en) data_q <= wdata;
            // write beats acknowledge so no update is lost
            if (wr_en)    dirty_q <= 1'b1;
            else if (ack) dirty_q <= 1'b0;
        end
    end

    assign data_o  = data_q;
    assign dirty_o = dirty_q;

    p_wr_loads_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (dirty_q && data_q == $past(wdata)));
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && !wr_en) |=> !dirty_q);
    p_collide_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && wr_en) |=> dirty_q);
    p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ack) |=> ($stable(data_q) && $stable(dirty_q)));
endmodule

// File: rtl/dbgmb_stdreg.sv
module dbgmb_stdreg
    import dbgmb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wdata,
    output byte_t q_o
);
    byte_t q;

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wdata;
    end

    assign q_o = q;

    p_std_load_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == $past(wdata)));
endmodule

// File: rtl/dbgmb_nvcfg.sv
module dbgmb_nvcfg #(
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              nv_rst,
    input  logic              lock_wr,
    input  logic [LOCK_W-1:0] lock_val,
    input  logic              fuse_wr,
    input  logic              fuse_val,
    input  logic              erase,
    output logic              fuse_o,
    output logic [LOCK_W-1:0] lock_o
);
    logic [LOCK_W-1:0] lock_q;
    logic              fuse_q;
    logic              locked;

    assign locked = |lock_q;

    always_ff @(posedge clk) begin
        if (nv_rst) begin
            lock_q <= '0;
        end else if (erase) begin
            lock_q <= '0;
        end else if (lock_wr) begin
            lock_q <= lock_q | lock_val;
        end
    end

    always_ff @(posedge clk) begin
        if (nv_rst)                 fuse_q <= 1'b0;
        else if (fuse_wr && !locked) fuse_q <= fuse_val;
    end

    assign fuse_o = fuse_q;
    assign lock_o = lock_q;

    p_locked_refuse_r9: assert property (@(posedge clk) disable iff (nv_rst)
        (fuse_wr && |lock_o) |=> $stable(fuse_o));
    p_erase_clears_r10: assert property (@(posedge clk) disable iff (nv_rst)
        erase |=> (lock_o == '0));
    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (nv_rst)
        !erase |=> ((lock_o & $past(lock_o)) == $past(lock_o)));
endmodule

// File: rtl/dbgmb_top.sv
module dbgmb_top
    import dbgmb_pkg::*;
#(
    parameter logic [AW-1:0] SHARED_ADDR = MBOX_IO_ADDR,
    parameter int            LOCK_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nv_rst,
    input  logic [AW-1:0]     io_addr_i,
    input  logic              io_wr_i,
    input  logic              io_rd_i,
    input  logic [DW-1:0]     io_wdata_i,
    output logic [DW-1:0]     io_rdata_o,
    input  logic              dbg_en_i,
    input  logic              dbg_ack_i,
    output logic [DW-1:0]     dbg_data_o,
    output logic              dbg_dirty_o,
    input  logic              lock_wr_i,
    input  logic [LOCK_W-1:0] lock_val_i,
    input  logic              fuse_wr_i,
    input  logic              fuse_val_i,
    input  logic              chip_erase_i,
    output logic              fuse_o,
    output logic [LOCK_W-1:0] lock_o
);
    io_req_t req;
    route_e  route;
    logic    hit, gate;
    logic    mbox_wr, std_wr;
    byte_t   mbox_q, std_q;
    logic    dirty_q, fuse_q;

    assign req   = '{wr: io_wr_i, rd: io_rd_i, addr: io_addr_i, wdata: io_wdata_i};
    assign hit   = (req.addr == SHARED_ADDR);
    assign gate  = fuse_q & dbg_en_i;
    assign route = pick_route(hit, gate);

    assign mbox_wr = req.wr && (route == RT_MBOX);
    assign std_wr  = req.wr && (route == RT_STD);

    dbgmb_mailbox u_mbox (
        .clk(clk), .rst(rst), .wr_en(mbox_wr), .wdata(req.wdata),
        .ack(dbg_ack_i), .data_o(mbox_q), .dirty_o(dirty_q)
    );

    dbgmb_stdreg u_std (
        .clk(clk), .rst(rst), .wr_en(std_wr), .wdata(req.wdata), .q_o(std_q)
    );

    dbgmb_nvcfg #(.LOCK_W(LOCK_W)) u_nv (
        .clk(clk), .nv_rst(nv_rst), .lock_wr(lock_wr_i), .lock_val(lock_val_i),
        .fuse_wr(fuse_wr_i), .fuse_val(fuse_val_i), .erase(chip_erase_i),
        .fuse_o(fuse_q), .lock_o(lock_o)
    );

    always_comb begin
        io_rdata_o = '0;
        if (req.rd) begin
            unique case (route)
                RT_MBOX: io_rdata_o = cpu_view(mbox_q, dirty_q);
                RT_STD:  io_rdata_o = std_q;
                default: io_rdata_o = '0;
            endcase
        end
    end

    assign dbg_data_o  = mbox_q;
    assign dbg_dirty_o = dirty_q;
    assign fuse_o      = fuse_q;

    p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !io_rd_i |-> (io_rdata_o == '0));
    p_closed_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (io_wr_i && !(fuse_o && dbg_en_i)) |=> $stable(dbg_data_o));
    p_miss_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        (io_addr_i != SHARED_ADDR) |=> $stable(dbg_data_o));
    p_dbg_full_byte_r4: assert property (@(posedge clk) disable iff (rst)
        (io_rd_i && io_addr_i == SHARED_ADDR && fuse_o && dbg_en_i) |->
        (io_rdata_o == {dbg_dirty_o, dbg_data_o[DW-2:0]}));
endmodule

// File: tb/sim_dbgmb_top.sv
module sim_dbgmb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1, nv_rst = 1'b1;
    logic [5:0] io_addr = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       dbg_en = 1'b0, dbg_ack = 1'b0;
    logic [7:0] dbg_data;
    logic       dbg_dirty;
    logic       lock_wr = 1'b0;
    logic [1:0] lock_val = '0;
    logic       fuse_wr = 1'b0, fuse_val = 1'b0, erase = 1'b0;
    logic       fuse;
    logic [1:0] lock;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbgmb_top u0 (
        .clk(clk), .rst(rst), .nv_rst(nv_rst), .io_addr_i(io_addr),
        .io_wr_i(io_wr), .io_rd_i(io_rd), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
        .dbg_en_i(dbg_en), .dbg_ack_i(dbg_ack), .dbg_data_o(dbg_data), .dbg_dirty_o(dbg_dirty),
        .lock_wr_i(lock_wr), .lock_val_i(lock_val), .fuse_wr_i(fuse_wr), .fuse_val_i(fuse_val),
        .chip_erase_i(erase), .fuse_o(fuse), .lock_o(lock)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [5:0] a, output logic [7:0] v);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        #1 v = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic fuse_write(input logic v);
        @(negedge clk); fuse_val = v; fuse_wr = 1'b1;
        @(negedge clk); fuse_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 data", dbg_data, 8'h00);
        check("R1 dirty", {7'd0, dbg_dirty}, 8'h00);
        check("R1 fuse", {7'd0, fuse}, 8'h00);
        check("R1 lock", {6'd0, lock}, 8'h00);
        io_read(6'h31, v);
        check("R1 std reg", v, 8'h00);
    endtask

    task automatic t_gate_closed();
        logic [7:0] v;
        fuse_write(1'b1);
        check("R10 fuse accepted unlocked", {7'd0, fuse}, 8'h01);
        dbg_en = 1'b0;
        io_write(6'h31, 8'hA5);
        check("R7 mbox untouched", dbg_data, 8'h00);
        check("R7 dirty untouched", {7'd0, dbg_dirty}, 8'h00);
        io_read(6'h31, v);
        check("R7 std reg readback", v, 8'hA5);
    endtask

    task automatic t_mbox_write();
        logic [7:0] v;
        dbg_en = 1'b1;
        io_write(6'h31, 8'h43);
        check("R2 data", dbg_data, 8'h43);
        check("R2 dirty", {7'd0, dbg_dirty}, 8'h01);
        io_read(6'h31, v);
        check("R3 cpu view", v, 8'hC3);
        io_write(6'h31, 8'hF0);
        check("R4 full byte", dbg_data, 8'hF0);
        io_read(6'h31, v);
        check("R3 cpu view top bit", v, 8'hF0);
        io_read(6'h31, v);
        check("R5 read keeps dirty", {7'd0, dbg_dirty}, 8'h01);
    endtask

    task automatic t_ack();
        logic [7:0] v;
        @(negedge clk); dbg_ack = 1'b1;
        @(negedge clk); dbg_ack = 1'b0;
        check("R5 ack clears", {7'd0, dbg_dirty}, 8'h00);
        io_read(6'h31, v);
        check("R3 cpu view clean", v, 8'h70);
        check("R4 byte kept", dbg_data, 8'hF0);
    endtask

    task automatic t_collide();
        @(negedge clk); io_addr = 6'h31; io_wdata = 8'h11; io_wr = 1'b1; dbg_ack = 1'b1;
        @(negedge clk); io_wr = 1'b0; dbg_ack = 1'b0;
        check("R6 data", dbg_data, 8'h11);
        check("R6 dirty kept", {7'd0, dbg_dirty}, 8'h01);
    endtask

    task automatic t_other_addr();
        logic [7:0] v;
        io_write(6'h30, 8'hFF);
        check("R8 mbox unchanged", dbg_data, 8'h11);
        io_read(6'h30, v);
        check("R8 miss reads zero", v, 8'h00);
        dbg_en = 1'b0;
        io_read(6'h31, v);
        check("R8 std unchanged", v, 8'hA5);
        dbg_en = 1'b1;
        @(negedge clk); io_addr = 6'h31; io_rd = 1'b0;
        #1 check("R11 idle read zero", io_rdata, 8'h00);
    endtask

    task automatic t_lock();
        @(negedge clk); lock_wr = 1'b1; lock_val = 2'b10;
        @(negedge clk); lock_wr = 1'b0;
        check("R10 lock set", {6'd0, lock}, 8'h02);
        fuse_write(1'b0);
        check("R9 fuse refused", {7'd0, fuse}, 8'h01);
        @(negedge clk); lock_wr = 1'b1; lock_val = 2'b00;
        @(negedge clk); lock_wr = 1'b0;
        check("R10 lock not cleared by write", {6'd0, lock}, 8'h02);
    endtask

    task automatic t_erase();
        @(negedge clk); erase = 1'b1; lock_wr = 1'b1; lock_val = 2'b01;
        @(negedge clk); erase = 1'b0; lock_wr = 1'b0;
        check("R10 erase clears locks", {6'd0, lock}, 8'h00);
        fuse_write(1'b0);
        check("R10 fuse accepted after erase", {7'd0, fuse}, 8'h00);
        io_write(6'h31, 8'h22);
        check("R7 fuse off closes gate", dbg_data, 8'h11);
        fuse_write(1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10 fuse survives rst", {7'd0, fuse}, 8'h01);
        check("R1 rst clears mbox", dbg_data, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0; nv_rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gate_closed();
        t_mbox_write();
        t_ack();
        t_collide();
        t_other_addr();
        t_lock();
        t_erase();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule